// File: doc/BRIEF.md
# Packed Shift and Precision Reduce Unit

This block performs the lane-wise shifts and precision-narrowing steps a signal-processing datapath needs on 32-bit words. Four signed bytes can each be shifted right arithmetically, optionally rounded. Two unsigned halfwords can each be shifted right logically. Two signed words can be scaled down and packed into one word of two halfwords. It also packs byte lanes and offers three funnel moves between two operands: append, prepend and byte align.

The datapath is purely combinational. Its result is captured in one output register, so a result appears one clock after its operands and opcode are presented. A new operation may be issued every cycle. Register-file access and operand forwarding belong to the surrounding pipeline.

Rounding adds back the last bit shifted out of a lane. The sum wraps inside the lane width and is never clamped.

Top module: `psr_unit`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it has been high, `result_o` is zero. Otherwise `result_o` equals the function of `op_i`, `src_a_i`, `src_b_i` and `amt_i` sampled at the previous rising edge.
- R2: Opcodes 0 (plain) and 1 (rounded) shift each of the four signed bytes of `src_b_i` right arithmetically by `amt_i[2:0]`. Bits 4:3 of `amt_i` have no effect. Byte k occupies bits 8k+7:8k.
- R3: In every rounded variant (opcodes 1 and 4), a lane whose original bit at position shift-1 is set gets 1 added to its shifted value. A shift of zero returns the lane unchanged. The sum is truncated to the lane width.
- R4: Opcode 2 shifts each unsigned halfword of `src_b_i` (bits 31:16 and 15:0) right logically by `amt_i[3:0]`, filling with zeros. Bit 4 of `amt_i` has no effect.
- R5: Opcodes 3 (plain) and 4 (rounded) shift both signed words `src_a_i` and `src_b_i` right arithmetically by `amt_i` (0 to 31). The low 16 bits of the shifted `src_a_i` go to bits 31:16 and the low 16 bits of the shifted `src_b_i` go to bits 15:0.
- R6: Opcode 5 returns {`src_a_i`[23:16], `src_a_i`[7:0], `src_b_i`[23:16], `src_b_i`[7:0]}.
- R7: Opcode 6 (append) returns `src_b_i` shifted left by `amt_i`, OR'ed with the low `amt_i` bits of `src_a_i`. A zero amount returns `src_b_i`.
- R8: Opcode 7 (prepend) returns `src_b_i` when `amt_i` is 0. Otherwise it returns (`src_a_i` << (32-`amt_i`)) | (`src_b_i` >> `amt_i`).
- R9: Opcode 8 (byte align) uses p = `amt_i[1:0]`. It returns `src_b_i` when p is 0, otherwise (`src_b_i` << 8p) | (`src_a_i` >> 8(4-p)).
- R10: Opcodes 9 to 15 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| src_a_i | input | 32 | Fill / high-pack operand |
| src_b_i | input | 32 | Shifted / base operand |
| amt_i | input | 5 | Shift amount or byte position |
| result_o | output | 32 | Registered result |

## Verification
Every opcode is swept over all 32 amounts against operands that stress lane sign bits. Typical patterns are 0x80 and 0x7F bytes, all-ones words and alternating bits. A design that leaked a sign or carry across a lane boundary, or read the unused upper amount bits, would corrupt neighbouring lanes at those patterns. Rounding at shift zero is a focus: a round bit taken from position -1 would add a spurious 1. Truncation of a rounded word is also covered: a result that saturated instead of truncating to 16 bits would differ at large negative and positive words. The zero-amount and zero-position edges of prepend, append and align are covered, where a naive 32-bit shift by 32 would return the wrong operand.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_BSRA     = 4'd0,
    OP_BSRA_RND = 4'd1,
    OP_HSRL     = 4'd2,
    OP_WPACK    = 4'd3,
    OP_WPACK_RND= 4'd4,
    OP_BPACK    = 4'd5,
    OP_APPEND   = 4'd6,
    OP_PREPEND  = 4'd7,
    OP_BALIGN   = 4'd8
  } psr_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd8;
endpackage

// File: rtl/psr_lane_sra.sv
// Arithmetic right shift of one lane with optional round-half-up.
// The lane is extended by one guard bit below the LSB; after the shift
// that guard bit holds the last bit shifted out (zero for a zero shift).
module psr_lane_sra #(
  parameter int LANE_W = 8,
  parameter int SH_W   = 3
) (
  input  logic [LANE_W-1:0] lane_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic              rnd_i,
  output logic [LANE_W-1:0] lane_o
);
  logic signed [LANE_W:0] ext;
  logic [LANE_W-1:0]      inc;

  always_comb begin
    ext    = $signed({lane_i, 1'b0}) >>> sh_i;
    inc    = {{(LANE_W-1){1'b0}}, rnd_i & ext[0]};
    lane_o = ext[LANE_W:1] + inc;
  end
endmodule

// File: rtl/psr_lane_unit.sv
// Packed lane shifts: signed bytes (arithmetic, optional round) and
// unsigned halfwords (logical).
module psr_lane_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  localparam int N_BYTE = DATA_W / BYTE_W,
  localparam int N_HALF = DATA_W / HALF_W,
  localparam int BSH_W  = $clog2(BYTE_W),
  localparam int HSH_W  = $clog2(HALF_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [HSH_W-1:0]  sh_i,
  input  logic              rnd_i,
  output logic [DATA_W-1:0] bsra_o,
  output logic [DATA_W-1:0] hsrl_o
);
  logic [BSH_W-1:0] bsh;
  assign bsh = sh_i[BSH_W-1:0];

  for (genvar gb = 0; gb < N_BYTE; gb++) begin : g_byte
    psr_lane_sra #(.LANE_W(BYTE_W), .SH_W(BSH_W)) u_sra (
      .lane_i (src_i[gb*BYTE_W +: BYTE_W]),
      .sh_i   (bsh),
      .rnd_i  (rnd_i),
      .lane_o (bsra_o[gb*BYTE_W +: BYTE_W])
    );
  end

  for (genvar gh = 0; gh < N_HALF; gh++) begin : g_half
    assign hsrl_o[gh*HALF_W +: HALF_W] = src_i[gh*HALF_W +: HALF_W] >> sh_i;
  end
endmodule

// File: rtl/psr_pack_unit.sv
// Precision reduction: word shift-and-pack, and byte-lane packing.
module psr_pack_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int N_SUB  = HALF_W / (2 * BYTE_W) * 2,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic              rnd_i,
  output logic [DATA_W-1:0] wpack_o,
  output logic [DATA_W-1:0] bpack_o
);
  localparam int N_HW = DATA_W / (2 * BYTE_W);

  logic [DATA_W-1:0] a_sh, b_sh;

  psr_lane_sra #(.LANE_W(DATA_W), .SH_W(SH_W)) u_sra_a (
    .lane_i (src_a_i), .sh_i (sh_i), .rnd_i (rnd_i), .lane_o (a_sh)
  );
  psr_lane_sra #(.LANE_W(DATA_W), .SH_W(SH_W)) u_sra_b (
    .lane_i (src_b_i), .sh_i (sh_i), .rnd_i (rnd_i), .lane_o (b_sh)
  );

  assign wpack_o = {a_sh[HALF_W-1:0], b_sh[HALF_W-1:0]};

  // Low byte of every halfword-sized group; src_a fills the upper half.
  for (genvar g = 0; g < N_HW; g++) begin : g_bp
    assign bpack_o[HALF_W + g*BYTE_W +: BYTE_W] = src_a_i[g*2*BYTE_W +: BYTE_W];
    assign bpack_o[g*BYTE_W +: BYTE_W]          = src_b_i[g*2*BYTE_W +: BYTE_W];
  end

  logic unused_n_sub;
  assign unused_n_sub = (N_SUB == 0);
endmodule

// File: rtl/psr_funnel_unit.sv
// Two-operand funnel moves: append, prepend, byte align.
module psr_funnel_unit #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int SH_W  = $clog2(DATA_W),
  localparam int BP_W  = $clog2(DATA_W / BYTE_W),
  localparam int BB_W  = $clog2(BYTE_W)
) (
  input  logic [DATA_W-1:0] fill_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [DATA_W-1:0] append_o,
  output logic [DATA_W-1:0] prepend_o,
  output logic [DATA_W-1:0] align_o
);
  logic [DATA_W-1:0]   low_mask;
  logic [2*DATA_W-1:0] pre_cat;
  logic [2*DATA_W-1:0] aln_cat;
  logic [SH_W:0]       aln_sh;
  logic [BP_W-1:0]     bp;

  always_comb begin
    low_mask  = ~({DATA_W{1'b1}} << sh_i);
    append_o  = (base_i << sh_i) | (fill_i & low_mask);

    // A zero shift selects the low word, i.e. the base, unchanged.
    pre_cat   = {fill_i, base_i} >> sh_i;
    prepend_o = pre_cat[DATA_W-1:0];

    // Shifting {base,fill} right by DATA_W-8p leaves the base for p=0.
    bp        = sh_i[BP_W-1:0];
    aln_sh    = (SH_W+1)'(DATA_W) - (SH_W+1)'({bp, {BB_W{1'b0}}});
    aln_cat   = {base_i, fill_i} >> aln_sh;
    align_o   = aln_cat[DATA_W-1:0];
  end
endmodule

// File: rtl/psr_unit.sv
// Packed shift and precision reduce unit, one-cycle registered result.
module psr_unit
  import psr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int HSH_W  = $clog2(HALF_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [SH_W-1:0]   amt_i,
  output logic [DATA_W-1:0] result_o
);
  psr_op_e           op;
  logic              lane_rnd, pack_rnd;
  logic [DATA_W-1:0] bsra, hsrl, wpack, bpack, app, pre, aln;
  logic [DATA_W-1:0] result_d;

  assign op       = psr_op_e'(op_i);
  assign lane_rnd = (op == OP_BSRA_RND);
  assign pack_rnd = (op == OP_WPACK_RND);

  psr_lane_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_lane (
    .src_i  (src_b_i),
    .sh_i   (amt_i[HSH_W-1:0]),
    .rnd_i  (lane_rnd),
    .bsra_o (bsra),
    .hsrl_o (hsrl)
  );

  psr_pack_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_pack (
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .sh_i    (amt_i),
    .rnd_i   (pack_rnd),
    .wpack_o (wpack),
    .bpack_o (bpack)
  );

  psr_funnel_unit #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_funnel (
    .fill_i    (src_a_i),
    .base_i    (src_b_i),
    .sh_i      (amt_i),
    .append_o  (app),
    .prepend_o (pre),
    .align_o   (aln)
  );

  always_comb begin
    case (op)
      OP_BSRA, OP_BSRA_RND:   result_d = bsra;
      OP_HSRL:                result_d = hsrl;
      OP_WPACK, OP_WPACK_RND: result_d = wpack;
      OP_BPACK:               result_d = bpack;
      OP_APPEND:              result_d = app;
      OP_PREPEND:             result_d = pre;
      OP_BALIGN:              result_d = aln;
      default:                result_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) result_o <= '0;
    else     result_o <= result_d;
  end
endmodule

// File: rtl/psr_unit_chk.sv
// Temporal checks on psr_unit ports, attached by bind.
module psr_unit_chk
  import psr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [SH_W-1:0]   amt_i,
  input logic [DATA_W-1:0] result_o
);
  localparam int HALF_W = DATA_W / 2;

  logic seen_rst;
  always_ff @(posedge clk) seen_rst <= seen_rst | rst;

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (result_o == '0)); // R1

  AST_BSRA_ZERO_SHIFT: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    ((op_i == OP_BSRA || op_i == OP_BSRA_RND) && amt_i[2:0] == 3'd0)
      |=> (result_o == $past(src_b_i))); // R3

  AST_HSRL_ZERO_FILL: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (op_i == OP_HSRL && amt_i[3:0] != 4'd0)
      |=> (!result_o[DATA_W-1] && !result_o[HALF_W-1])); // R4

  AST_BPACK_LANES: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (op_i == OP_BPACK)
      |=> (result_o[31:24] == $past(src_a_i[23:16]) && result_o[7:0] == $past(src_b_i[7:0]))); // R6

  AST_APPEND_LOW: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (op_i == OP_APPEND && amt_i == '0) |=> (result_o == $past(src_b_i))); // R7

  AST_PREPEND_ZERO: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (op_i == OP_PREPEND && amt_i == '0) |=> (result_o == $past(src_b_i))); // R8

  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (op_i == OP_BALIGN && amt_i[1:0] == 2'd0) |=> (result_o == $past(src_b_i))); // R9

  AST_UNDEF_OP_ZERO: assert property (@(posedge clk) disable iff (rst || !seen_rst)
    (op_i > OP_LAST) |=> (result_o == '0)); // R10
endmodule

bind psr_unit psr_unit_chk #(.DATA_W(DATA_W)) u_psr_unit_chk (
  .clk      (clk),
  .rst      (rst),
  .op_i     (op_i),
  .src_a_i  (src_a_i),
  .src_b_i  (src_b_i),
  .amt_i    (amt_i),
  .result_o (result_o)
);

// File: tb/test_psr_unit.sv
`timescale 1ns/1ps
module test_psr_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op  = 4'd0;
  logic [31:0] a   = 32'h0;
  logic [31:0] b   = 32'h0;
  logic [4:0]  amt = 5'd0;
  logic [31:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psr_unit i_psr_unit (
    .clk(clk), .rst(rst), .op_i(op), .src_a_i(a), .src_b_i(b),
    .amt_i(amt), .result_o(result)
  );

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    logic [31:0] r;
    int v, q, sh;
    longint lv, lq;
    logic [31:0] ra, rb;
    r = 32'h0;
    case (o)
      4'd0, 4'd1: begin
        sh = int'(s[2:0]);
        for (int k = 0; k < 4; k++) begin
          v = int'($signed(y[8*k +: 8]));
          q = v >>> sh;
          if (o == 4'd1 && sh > 0) q = q + ((v >>> (sh - 1)) & 1);
          r[8*k +: 8] = q[7:0];
        end
      end
      4'd2: begin
        for (int k = 0; k < 2; k++) r[16*k +: 16] = y[16*k +: 16] >> s[3:0];
      end
      4'd3, 4'd4: begin
        sh = int'(s);
        lv = longint'($signed(x));
        lq = lv >>> sh;
        if (o == 4'd4 && sh > 0) lq = lq + ((lv >>> (sh - 1)) & 1);
        ra = lq[31:0];
        lv = longint'($signed(y));
        lq = lv >>> sh;
        if (o == 4'd4 && sh > 0) lq = lq + ((lv >>> (sh - 1)) & 1);
        rb = lq[31:0];
        r = {ra[15:0], rb[15:0]};
      end
      4'd5: r = {x[23:16], x[7:0], y[23:16], y[7:0]};
      4'd6: r = (y << s) | (x & ((32'h1 << s) - 32'h1));
      4'd7: r = (s == 5'd0) ? y : ((x << (32 - int'(s))) | (y >> s));
      4'd8: r = (s[1:0] == 2'd0) ? y :
                ((y << (8 * int'(s[1:0]))) | (x >> (8 * (4 - int'(s[1:0])))));
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R3/R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h amt=%0d actual=%h expected=%h",
               req, op, a, b, amt, got, exp);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, compare at the next falling edge.
  task automatic run(input logic [3:0] o, input logic [31:0] x,
                     input logic [31:0] y, input logic [4:0] s);
    @(negedge clk);
    op = o; a = x; b = y; amt = s;
    @(negedge clk);
    check(req_of(o), result, model(o, x, y, s));
  endtask

  logic [31:0] pat [12];
  logic [31:0] lfsr;

  initial begin
    pat[0] = 32'h0000_0000; pat[1]  = 32'hFFFF_FFFF; pat[2]  = 32'h8080_8080;
    pat[3] = 32'h7F7F_7F7F; pat[4]  = 32'h1234_5678; pat[5]  = 32'h89AB_CDEF;
    pat[6] = 32'h8000_7FFF; pat[7]  = 32'h55AA_33CC; pat[8]  = 32'h7FFF_FFFF;
    pat[9] = 32'h8000_0000; pat[10] = 32'hC3C3_0101; pat[11] = 32'h0180_FF7E;

    // R1: output held at zero during reset with busy inputs
    op = 4'd5; a = 32'hDEAD_BEEF; b = 32'hCAFE_F00D; amt = 5'd7;
    repeat (3) @(negedge clk);
    check("R1", result, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", result, model(4'd5, 32'hDEAD_BEEF, 32'hCAFE_F00D, 5'd7));

    // R2..R9: every opcode over every amount and operand pattern
    lfsr = 32'hACE1_1234;
    for (int o = 0; o <= 8; o++) begin
      for (int s = 0; s < 32; s++) begin
        for (int p = 0; p < 12; p++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          run(4'(o), pat[(p + 5) % 12] ^ ((p > 8) ? lfsr : 32'h0), pat[p], 5'(s));
        end
      end
    end

    // R3: rounding examples with hand-computed results
    run(4'd1, 32'h0, 32'h7F81_0301, 5'd1);
    check("R3", result, 32'h40C1_0201);
    run(4'd4, 32'h7FFF_FFFF, 32'h8000_0001, 5'd1);
    check("R3", result, 32'h0000_0001);

    // R10: undefined opcodes give zero
    for (int o = 9; o < 16; o++) begin
      for (int p = 0; p < 4; p++) run(4'(o), pat[p + 4], pat[p + 1], 5'(3 * p + o));
    end

    // R1: reset asserted mid-stream clears the output
    @(negedge clk);
    op = 4'd8; a = 32'h1111_2222; b = 32'h3333_4444; amt = 5'd1;
    rst = 1'b1;
    @(negedge clk);
    check("R1", result, 32'h0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule